// File: doc/BRIEF.md
# Reference Clock Presence Monitor

This block decides whether a slow reference clock, nominally 8 kHz, is reaching the chip. All of its timing comes from a fast local clock that runs at a fixed multiple of the reference rate. The reference pin is asynchronous to that clock, so it is brought into the local domain first. The block then counts low-to-high transitions over a fixed observation window and judges the reference from that count.

Each window spans three reference periods. With the default ratio of 4416 local cycles per reference period, that is 13248 local cycles. When a window holds at least two rising edges, the reference is declared present. When it holds fewer, the reference is declared lost.

The verdict drives a select line for the frequency-tracking loop. While the reference is lost, `hold_centre` is high and the loop parks the oscillator control at its mid value. When the reference is seen again, `hold_centre` drops so that the loop can track the reference again.

Top module: `ref_presence_monitor`

## Requirements
- R1: The reference passes through a two-flop synchronizer. Only a 0-to-1 change of the synchronized level counts as an edge, so a level held high for a whole window adds no edges after its first rise.
- R2: Windows are exactly WIN_CYCLES local clock cycles long and follow one another without gap or overlap. The first window starts on the first clock edge after reset is released.
- R3: A window that ends with fewer than MIN_EDGES (default 2) counted rising edges sets ref_present to 0 and ref_lost to 1.
- R4: A window that ends with MIN_EDGES or more counted rising edges sets ref_present to 1 and ref_lost to 0.
- R5: While the reference is declared lost, hold_centre is 1.
- R6: While the reference is declared present, hold_centre is 0.
- R7: During reset and until the first window verdict, ref_present is 0, ref_lost is 1 and hold_centre is 1.
- R8: The per-window edge count saturates at 3. A window with many more edges than three still gives a present verdict and never wraps into a lost one.
- R9: The three outputs change only on the clock edge that closes a window. The verdict takes effect one cycle after the window's last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, WIN_CYCLES/3 times the reference rate |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference clock input |
| ref_present | output | 1 | 1 when the last window saw enough rising edges |
| ref_lost | output | 1 | Complement of ref_present |
| hold_centre | output | 1 | 1 selects the centre oscillator control; 0 selects tracking |

## Verification
The reference is driven with a fast period that yields three edges per window, and with a period that yields exactly two edges, which sits on the threshold. It is also driven with a slow period that yields at most one edge, and with a level stuck high. These patterns separate a correct threshold from one that is off by one, and show that levels are not counted as edges. A very fast burst of many edges per window shows whether the count saturates or wraps. Every cycle is compared with a behavioural model, so the model also checks that a verdict lands only one cycle after a window's last cycle and never in between.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    typedef enum logic {
        REF_LOST = 1'b0,
        REF_OK   = 1'b1
    } ref_state_e;

    // Saturating add used by the edge counter.
    function automatic int unsigned sat_add(int unsigned a, int unsigned b, int unsigned lim);
        int unsigned s;
        s = a + b;
        return (s > lim) ? lim : s;
    endfunction

endpackage

// File: rtl/refmon_sync.sv
module refmon_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic rise_pulse
);
    // pipe[0..SYNC_STAGES-1] synchronize; pipe[SYNC_STAGES] holds the prior level
    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[SYNC_STAGES-1:0], ref_in};
    end

    assign rise_pulse = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];

    // R1: a detected rise lasts exactly one cycle
    a_r1_single_cycle_rise: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/refmon_window.sv
module refmon_window #(
    parameter int WIN_CYCLES = 13248
) (
    input  logic clk,
    input  logic rst,
    output logic win_end
);
    localparam int WW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WW-1:0] LAST = WW'(WIN_CYCLES - 1);

    logic [WW-1:0] cnt_q;

    assign win_end = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (win_end) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    // R2: inside a window the position advances by one each cycle
    a_r2_window_advance: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R2: a closed window is followed at once by a fresh one
    a_r2_window_restart: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (cnt_q == '0));

endmodule

// File: rtl/refmon_edge_count.sv
module refmon_edge_count
    import refmon_pkg::*;
#(
    parameter int MAX_COUNT = 3,
    parameter int CW        = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          edge_in,
    input  logic          clr,
    output logic [CW-1:0] total
);
    logic [CW-1:0] cnt_q;

    // count including any edge seen on the current cycle
    assign total = CW'(sat_add(32'(cnt_q), 32'(edge_in), MAX_COUNT));

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= total;
    end

    // R8: a saturated count stays saturated when more edges arrive
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CW'(MAX_COUNT) && edge_in && !clr) |=> (cnt_q == CW'(MAX_COUNT)));

    // R2: the count starts from zero in each new window
    a_r2_count_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/ref_presence_monitor.sv
module ref_presence_monitor
    import refmon_pkg::*;
#(
    parameter int WIN_CYCLES  = 13248,
    parameter int MIN_EDGES   = 2,
    parameter int MAX_COUNT   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic ref_present,
    output logic ref_lost,
    output logic hold_centre
);
    localparam int CW = $clog2(MAX_COUNT + 1);

    logic          rise;
    logic          win_end;
    logic [CW-1:0] total;
    ref_state_e    state_q;
    logic          hold_q;

    refmon_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ref_in(ref_in), .rise_pulse(rise)
    );

    refmon_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
        .clk(clk), .rst(rst), .win_end(win_end)
    );

    refmon_edge_count #(.MAX_COUNT(MAX_COUNT), .CW(CW)) u_count (
        .clk(clk), .rst(rst), .edge_in(rise), .clr(win_end), .total(total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= REF_LOST;
            hold_q  <= 1'b1;
        end else if (win_end) begin
            if (32'(total) >= MIN_EDGES) begin
                state_q <= REF_OK;
                hold_q  <= 1'b0;
            end else begin
                state_q <= REF_LOST;
                hold_q  <= 1'b1;
            end
        end
    end

    assign ref_present = (state_q == REF_OK);
    assign ref_lost    = ~ref_present;
    assign hold_centre = hold_q;

    // R7: reset forces the lost verdict and centre hold
    a_r7_reset_state: assert property (@(posedge clk)
        rst |=> (!ref_present && hold_centre));

    // R9: outputs hold their value except when a window closes
    a_r9_update_at_end: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> ($stable(ref_present) && $stable(hold_centre)));

    // R4: enough edges give a present verdict
    a_r4_present_verdict: assert property (@(posedge clk) disable iff (rst)
        (win_end && 32'(total) >= MIN_EDGES) |=> ref_present);

    // R3: too few edges give a lost verdict
    a_r3_lost_verdict: assert property (@(posedge clk) disable iff (rst)
        (win_end && 32'(total) < MIN_EDGES) |=> ref_lost);

    // R5 R6: centre hold follows the lost verdict
    a_r5_hold_matches_lost: assert property (@(posedge clk) disable iff (rst)
        hold_centre == ref_lost);

endmodule

// File: tb/ref_presence_monitor_bench.sv
module ref_presence_monitor_bench;

    localparam int WIN = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic ref_present, ref_lost, hold_centre;

    int total_checks = 0;
    int bad_checks   = 0;

    always #5 clk = ~clk;

    ref_presence_monitor #(.WIN_CYCLES(WIN)) u_ref_presence_monitor (
        .clk(clk), .rst(rst), .ref_in(ref_in),
        .ref_present(ref_present), .ref_lost(ref_lost), .hold_centre(hold_centre)
    );

    // Behavioural model: history of sampled reference levels, window position,
    // saturating edge tally and the current verdict.
    bit hist[$] = '{0, 0, 0};
    int m_pos = 0;
    int m_edges = 0;
    bit m_present = 0;

    always @(posedge clk) begin
        if (rst) begin
            hist = '{0, 0, 0};
            m_pos = 0; m_edges = 0; m_present = 0;
        end else begin
            int e;
            int t;
            e = (hist[1] && !hist[2]) ? 1 : 0;
            t = m_edges + e;
            if (t > 3) t = 3;
            if (m_pos == WIN - 1) begin
                m_present = (t >= 2);
                m_edges = 0;
                m_pos = 0;
            end else begin
                m_edges = t;
                m_pos = m_pos + 1;
            end
            hist.push_front(ref_in);
            void'(hist.pop_back());
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        total_checks++;
        if (act !== exp) begin
            bad_checks++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            check("R3 R4 R9 ref_present", ref_present, m_present);
            check("R3 R4 ref_lost", ref_lost, !m_present);
            check("R5 R6 hold_centre", hold_centre, !m_present);
        end
    end

    // Drive a square wave of the given period for n cycles (changes at negedge).
    task automatic drive_wave(input int period, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_in = ((i % period) < (period / 2));
        end
    endtask

    task automatic drive_level(input logic lvl, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_in = lvl;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad_checks++;
        total_checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R7: reset state
        check("R7 present in reset", ref_present, 1'b0);
        check("R7 lost in reset", ref_lost, 1'b1);
        check("R7 hold in reset", hold_centre, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        // R7: still lost before first verdict, even with a good reference
        drive_wave(16, WIN - 5);
        check("R7 before first verdict", hold_centre, 1'b1);

        // R4 R6: three edges per window
        drive_wave(16, 4 * WIN);
        check("R4 fast reference present", ref_present, 1'b1);
        check("R6 hold released", hold_centre, 1'b0);

        // R3 R5: slow reference, at most one edge per window
        drive_wave(60, 4 * WIN);
        check("R3 slow reference lost", ref_lost, 1'b1);
        check("R5 hold asserted", hold_centre, 1'b1);

        // R4: exactly two edges per window (threshold)
        drive_wave(24, 5 * WIN);
        check("R4 two edges present", ref_present, 1'b1);

        // R1: stuck-high level is not a stream of edges
        drive_level(1'b1, 3 * WIN);
        check("R1 stuck high lost", ref_present, 1'b0);

        // R8: very fast burst saturates, stays present
        drive_wave(2, 4 * WIN);
        check("R8 saturated present", ref_present, 1'b1);

        // R3: reference removed (stuck low)
        drive_level(1'b0, 3 * WIN);
        check("R3 stuck low lost", ref_lost, 1'b1);

        // R2 R9: recover, model confirms verdict timing cycle by cycle
        drive_wave(12, 3 * WIN);
        check("R2 recovered present", ref_present, 1'b1);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

endmodule